// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the slave-side command engine of a 512-byte serial EEPROM. It runs on a fast system clock. Chip select, serial clock and serial input arrive already synchronized. The engine finds serial-clock edges by comparing the current level with the level registered one cycle earlier. It takes in bits on falling edges and moves the serial output after rising edges. The serial clock idles high between frames.

Each frame starts with an 8-bit command. The engine can set or clear a write-enable latch, return a status byte, update two block-protect bits, stream array data, or buffer up to four bytes for a page program. Programming is modelled by a down-counter. When the count ends, the buffered bytes are committed to an inferred single-port byte array.

An external checker judges protection. It reads the protect level and the page being programmed, and can veto a program as the frame closes.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset `so_oe`, `busy` and `bp_level` are 0, and a status read returns 0x00.
- R2: Command 0x05 returns the status byte MSB first. Bits 7:4 are 0, bits 3:2 hold the protect level, bit 1 the write-enable latch and bit 0 busy. Each output bit appears after a rising serial-clock edge, and the first one after the rising edge that follows the command's eighth falling edge.
- R3: Command 0x06 sets the write-enable latch and command 0x04 clears it.
- R4: Command `0000_h011` (h = address bit 8) followed by an address byte streams array bytes from that address. The address increments after each byte and wraps from 0x1FF to 0x000.
- R5: Command `0000_h010` followed by an address byte buffers data bytes. After each byte only address bits 1:0 step. A fifth or later byte wraps inside the 4-byte page and replaces the earlier byte at that offset.
- R6: A program starts only when chip select rises with at least one complete data byte and no further bits clocked in after it. Otherwise the buffered data is discarded.
- R7: A write or status-write command received while the latch is clear changes neither the array nor the protect level, and starts no program.
- R8: Once a program starts, `busy` is high for PROG_CYCLES+4 cycles and the latch reads 0. The array holds the buffered bytes once `busy` falls.
- R9: While busy, every command other than 0x05 is ignored. In particular, 0x06 does not set the latch.
- R10: Command 0x01 followed by a data byte sets the protect level from data bits 3:2 when its program completes.
- R11: After an unknown command `so_oe` stays 0 for the rest of the frame, and the latch is unchanged.
- R12: If `wr_block` is high when chip select rises, no program starts, the array is unchanged and the latch keeps its value.
- R13: `so_oe` is 0 while the command and address bytes shift in, and in the cycle after chip select is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, synchronized |
| sck | input | 1 | Serial clock, synchronized, idles high |
| si | input | 1 | Serial data in, synchronized |
| wr_block | input | 1 | Veto from the protection checker, sampled when chip select rises |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (0 = high impedance) |
| busy | output | 1 | Program in progress |
| bp_level | output | 2 | Current block-protect level |
| wr_page | output | ADDR_W-2 | Page address of the pending or running program |

## Verification
The assertions assume that every serial-clock level lasts several system clocks. Each edge must appear as a single-cycle difference between the registered and current sample. They also assume that chip select changes only while the serial clock is high. The bench holds each serial-clock phase for four system clocks. It changes serial input and chip select only during the high phase or between frames, and it moves every input on the falling system-clock edge.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_WDATA,
    PH_SDATA,
    PH_OUT,
    PH_SKIP
  } phase_t;

  localparam logic [7:0] CMD_SET_WEL = 8'h06;
  localparam logic [7:0] CMD_CLR_WEL = 8'h04;
  localparam logic [7:0] CMD_STATUS  = 8'h05;
  localparam logic [7:0] CMD_SET_BP  = 8'h01;
  localparam logic [2:0] CMD_RD_TAIL = 3'b011;
  localparam logic [2:0] CMD_WR_TAIL = 3'b010;
endpackage

// File: rtl/spi_ee_edges.sv
module spi_ee_edges (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  output logic sck_fall,
  output logic sck_rise,
  output logic cs_rise
);
  logic sck_q, cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b1;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign sck_fall = sck_q & ~sck & ~cs_n;
  assign sck_rise = ~sck_q & sck & ~cs_n;
  assign cs_rise  = cs_n & ~cs_q;
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_ee_timer.sv
module spi_ee_timer #(
  parameter int PROG_CYCLES = 1000,
  parameter int SLOTS       = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  output logic                     busy,
  output logic                     slot_valid,
  output logic [$clog2(SLOTS)-1:0] slot,
  output logic                     done
);
  localparam int CW     = $clog2(PROG_CYCLES + SLOTS + 1);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [CW-1:0] TOTAL = CW'(PROG_CYCLES + SLOTS);
  localparam logic [CW-1:0] NSLOT = CW'(SLOTS);

  logic [CW-1:0] cnt;
  logic [CW-1:0] slot_full;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (start && !busy) cnt <= TOTAL;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy       = (cnt != '0);
  assign slot_valid = busy && (cnt <= NSLOT);
  assign slot_full  = NSLOT - cnt;
  assign slot       = slot_full[SLOT_W-1:0];
  assign done       = (cnt == CW'(1));
endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 4,
  parameter int PROG_CYCLES = 1000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cs_n,
  input  logic                         sck,
  input  logic                         si,
  input  logic                         wr_block,
  output logic                         so,
  output logic                         so_oe,
  output logic                         busy,
  output logic [1:0]                   bp_level,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] wr_page
);
  import spi_ee_pkg::*;

  localparam int OFS_W = $clog2(PAGE_BYTES);

  logic sck_fall, sck_rise, cs_rise;
  phase_t phase;
  logic [2:0] bitcnt;
  logic [6:0] shreg;
  logic [7:0] byte_in, cur_byte, ram_q;
  logic byte_done, is_read, stat_rd, a_hi, armed, wel, prog_sr, start;
  logic [ADDR_W-1:0] addr;
  logic [1:0] sr_new;
  logic [7:0] wbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] wmask;
  logic slot_valid, done, ram_we;
  logic [OFS_W-1:0] slot;

  spi_ee_edges u_edges (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck),
    .sck_fall(sck_fall), .sck_rise(sck_rise), .cs_rise(cs_rise)
  );

  spi_ee_timer #(.PROG_CYCLES(PROG_CYCLES), .SLOTS(PAGE_BYTES)) u_timer (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .slot_valid(slot_valid), .slot(slot), .done(done)
  );

  assign ram_we = slot_valid && !prog_sr && wmask[slot];

  spi_ee_array #(.AW(ADDR_W), .DW(8)) u_array (
    .clk(clk), .we(ram_we), .waddr({addr[ADDR_W-1:OFS_W], slot}),
    .wdata(wbuf[slot]), .raddr(addr), .rdata(ram_q)
  );

  assign byte_in   = {shreg, si};
  assign byte_done = sck_fall && (bitcnt == 3'd7);
  assign cur_byte  = stat_rd ? {4'b0000, bp_level, wel, busy} : ram_q;
  assign start     = cs_rise && armed && !busy && !wr_block &&
                     ((phase == PH_WDATA) || (phase == PH_SDATA));
  assign wr_page   = addr[ADDR_W-1:OFS_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_CMD;
      bitcnt   <= '0;
      shreg    <= '0;
      is_read  <= 1'b0;
      stat_rd  <= 1'b0;
      a_hi     <= 1'b0;
      armed    <= 1'b0;
      wel      <= 1'b0;
      prog_sr  <= 1'b0;
      addr     <= '0;
      sr_new   <= '0;
      wmask    <= '0;
      bp_level <= '0;
      so       <= 1'b0;
      so_oe    <= 1'b0;
    end else begin
      if (start) begin
        wel     <= 1'b0;
        prog_sr <= (phase == PH_SDATA);
      end
      if (done && prog_sr) bp_level <= sr_new;
      if (cs_n) begin
        phase  <= PH_CMD;
        bitcnt <= '0;
        armed  <= 1'b0;
        so_oe  <= 1'b0;
      end else begin
        if (sck_fall) begin
          bitcnt <= bitcnt + 3'd1;
          shreg  <= byte_in[6:0];
          armed  <= 1'b0;
        end
        if (byte_done) begin
          case (phase)
            PH_CMD: begin
              phase <= PH_SKIP;
              if (byte_in == CMD_STATUS) begin
                phase   <= PH_OUT;
                stat_rd <= 1'b1;
              end else if (!busy) begin
                if (byte_in == CMD_SET_WEL) wel <= 1'b1;
                if (byte_in == CMD_CLR_WEL) wel <= 1'b0;
                if (byte_in == CMD_SET_BP && wel) phase <= PH_SDATA;
                if (byte_in[7:4] == 4'h0 && byte_in[2:0] == CMD_RD_TAIL) begin
                  phase   <= PH_ADDR;
                  is_read <= 1'b1;
                  a_hi    <= byte_in[3];
                end
                if (byte_in[7:4] == 4'h0 && byte_in[2:0] == CMD_WR_TAIL && wel) begin
                  phase   <= PH_ADDR;
                  is_read <= 1'b0;
                  a_hi    <= byte_in[3];
                end
              end
            end
            PH_ADDR: begin
              addr  <= ADDR_W'({a_hi, byte_in});
              wmask <= '0;
              if (is_read) begin
                phase   <= PH_OUT;
                stat_rd <= 1'b0;
              end else begin
                phase <= PH_WDATA;
              end
            end
            PH_WDATA: begin
              wmask[addr[OFS_W-1:0]] <= 1'b1;
              addr[OFS_W-1:0]        <= addr[OFS_W-1:0] + 1'b1;
              armed                  <= 1'b1;
            end
            PH_SDATA: begin
              sr_new <= byte_in[3:2];
              armed  <= 1'b1;
            end
            PH_OUT: if (!stat_rd) addr <= addr + 1'b1;
            default: ;
          endcase
        end
        if (sck_rise && phase == PH_OUT) begin
          so_oe <= 1'b1;
          so    <= cur_byte[3'd7 - bitcnt];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!cs_n && byte_done && phase == PH_WDATA) wbuf[addr[OFS_W-1:0]] <= byte_in;
  end

  // R13: output released once chip select is high
  a_r13_oe_off_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !so_oe);
  // R2: output bit moves only after a rising serial-clock edge
  a_r2_so_after_rise: assert property (@(posedge clk) disable iff (rst)
    (so_oe && $past(so_oe) && !$stable(so)) |-> $past(sck_rise));
  // R6: programming begins only as chip select goes high
  a_r6_prog_on_deselect: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cs_n));
  // R8: latch reads clear once programming runs
  a_r8_wel_clear_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !wel);
  // R9: latch cannot be set while busy
  a_r9_no_wel_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> !$rose(wel));
endmodule

// File: tb/spi_eeprom_engine_tb.sv
module spi_eeprom_engine_tb;
  localparam int PROG = 600;
  localparam int TOTAL = PROG + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b1, si = 1'b0, wr_block = 1'b0;
  logic so, so_oe, busy;
  logic [1:0] bp_level;
  logic [6:0] wr_page;

  always #2 clk = ~clk;

  spi_eeprom_engine #(.ADDR_W(9), .PAGE_BYTES(4), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .wr_block(wr_block),
    .so(so), .so_oe(so_oe), .busy(busy), .bp_level(bp_level), .wr_page(wr_page)
  );

  int nchk = 0, nerr = 0;
  int m_mem [512];
  bit m_wel = 0;
  int m_bp = 0;
  int m_left = 0;
  bit run = 0;
  logic cs_seen = 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cs_seen <= cs_n;

  always @(negedge clk) begin
    if (run) begin
      chk(busy == (m_left > 0), "R8 busy window", int'(busy), int'(m_left > 0));
      chk(!(cs_seen && so_oe), "R13 oe after deselect", int'(so_oe), 0);
      if (m_left > 0) m_left--;
    end
  end

  task automatic bits(input logic [7:0] tx, input int nb, output logic [7:0] rx,
                      output logic oe_all, output logic oe_any);
    rx = '0; oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 8 - nb; i--) begin
      si = tx[i];
      repeat (2) @(negedge clk);
      rx[i] = so; oe_all &= so_oe; oe_any |= so_oe;
      sck = 1'b0;
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic begin_frame();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic end_frame(input bit expect_prog);
    cs_n = 1'b1;
    @(posedge clk);
    if (expect_prog) m_left = TOTAL;
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (m_left > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] rx; logic a, o;
    begin_frame();
    bits(op, 8, rx, a, o);
    chk(!o, "R13 oe during command", int'(o), 0);
    end_frame(0);
  endtask

  task automatic rdsr(input string tag, input int exp);
    logic [7:0] rx; logic a, o;
    begin_frame();
    bits(8'h05, 8, rx, a, o);
    chk(!o, "R13 oe during command", int'(o), 0);
    bits(8'h00, 8, rx, a, o);
    chk(a, "R2 oe during status", int'(a), 1);
    chk(rx == exp[7:0], tag, int'(rx), exp);
    end_frame(0);
  endtask

  task automatic rd(input int adr, input int n, input string tag);
    logic [7:0] rx; logic a, o;
    begin_frame();
    bits({4'h0, adr[8], 3'b011}, 8, rx, a, o);
    bits(adr[7:0], 8, rx, a, o);
    chk(!o, "R13 oe during address", int'(o), 0);
    for (int k = 0; k < n; k++) begin
      bits(8'h00, 8, rx, a, o);
      chk(a && rx == m_mem[(adr + k) % 512][7:0], tag, int'(rx), m_mem[(adr + k) % 512]);
    end
    end_frame(0);
  endtask

  task automatic wr(input int adr, input int d[], input int extra, input bit expect_prog);
    logic [7:0] rx; logic a, o;
    begin_frame();
    bits({4'h0, adr[8], 3'b010}, 8, rx, a, o);
    bits(adr[7:0], 8, rx, a, o);
    foreach (d[k]) bits(d[k][7:0], 8, rx, a, o);
    if (extra > 0) bits(8'hA5, extra, rx, a, o);
    end_frame(expect_prog);
    if (expect_prog) begin
      m_wel = 0;
      foreach (d[k]) m_mem[(adr & ~3) | ((adr + k) & 3)] = d[k];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] rx; logic a, o;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    run = 1;
    chk(so_oe == 0 && busy == 0, "R1 reset outputs", int'({so_oe, busy}), 0);
    chk(bp_level == 0, "R1 reset protect level", int'(bp_level), 0);
    rdsr("R1 reset status", 8'h00);

    cmd(8'h06); m_wel = 1;
    rdsr("R3 latch set", 8'h02);
    cmd(8'h04); m_wel = 0;
    rdsr("R3 latch cleared", 8'h00);

    // page at the top of the array, address bit 8 in the command
    cmd(8'h06); m_wel = 1;
    wr(9'h1FC, '{8'hA1, 8'hA2, 8'hA3, 8'hA4}, 0, 1);
    chk(wr_page == 7'h7F, "R5 page output", int'(wr_page), 'h7F);
    rdsr("R8 status while busy", 8'h01);
    cmd(8'h06);
    rdsr("R9 set-latch ignored while busy", 8'h01);
    wait_idle();

    // six bytes wrap inside page 0
    cmd(8'h06); m_wel = 1;
    wr(0, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}, 0, 1);
    wait_idle();
    chk(m_mem[0] == 'h55 && m_mem[2] == 'h33, "R5 model wrap", m_mem[0], 'h55);
    rd(9'h1FE, 4, "R4 read across top wrap");
    rd(9'h000, 4, "R5 page contents");

    wr(0, '{8'hEE}, 0, 0);
    rd(0, 1, "R7 write without latch ignored");

    cmd(8'h06); m_wel = 1;
    wr(1, '{8'h99}, 3, 0);
    rd(1, 1, "R6 partial byte discards program");

    wr_block = 1'b1;
    wr(2, '{8'h77}, 0, 0);
    wr_block = 1'b0;
    rd(2, 1, "R12 vetoed program");

    begin_frame();
    bits(8'h07, 8, rx, a, o);
    bits(8'h00, 8, rx, a, o);
    bits(8'h00, 8, rx, a, o);
    chk(!o, "R11 unknown command keeps output off", int'(o), 0);
    end_frame(0);
    rdsr("R11 R12 latch unchanged", 8'h02);

    begin_frame();
    bits(8'h01, 8, rx, a, o);
    bits(8'hFC, 8, rx, a, o);
    end_frame(1);
    m_wel = 0; m_bp = 3;
    wait_idle();
    chk(bp_level == 2'd3, "R10 protect level", int'(bp_level), 3);
    rdsr("R10 status shows level", 8'h0C);

    begin_frame();
    bits(8'h01, 8, rx, a, o);
    bits(8'h00, 8, rx, a, o);
    end_frame(0);
    chk(bp_level == 2'd3, "R7 status write without latch", int'(bp_level), 3);

    run = 0;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule